// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short history of where the program went. Each time the core takes a branch or jump, a strobe delivers the 32-bit fetch address of that change-of-flow instruction. The block stores it in an eight-slot ring, overwriting the oldest slot once all eight are full. While the core runs normally, the history always holds the last eight such addresses.

When the debug-mode flag rises, capture stops and the read position is set to the oldest stored address. A debug host then issues read strobes. Each strobe returns one address and moves the read position forward by one slot. Reads do not remove entries. After eight reads the position is back where it began, so the same history can be read again as often as needed. When debug mode is left, capture resumes at the slot where it stopped.

Top module: `cof_trace_buf`

## Requirements
- R1: Outside debug mode, each `cof_valid` pulse stores `cof_addr` into the slot at the write position and advances that position by one, modulo 8. The ninth and later captures overwrite the oldest slot.
- R2: While `rst_n` is low, all eight slots clear to zero, both positions return to slot 0 and `rd_data` becomes zero.
- R3: In the first clock cycle in which `dbg_mode` is high after being low (the entry cycle), the read position is loaded with the write position. This is the slot holding the oldest of the eight stored addresses.
- R4: A read strobe accepted in debug mode places the slot at the read position on `rd_data` one clock later and advances the read position by one, modulo 8. Eight accepted reads return the position to its start, so a second pass of eight reads repeats the first.
- R5: Within one pass of eight reads, the addresses come out from oldest to newest in the order they were captured. Slots never written since reset read as zero.
- R6: Reads never change any stored address.
- R7: While `dbg_mode` is high, `cof_valid` pulses are ignored: no slot and no write position changes.
- R8: A read strobe outside debug mode, or in the entry cycle, is ignored. Neither `rd_data` nor the read position changes.
- R9: `rd_data` holds its value in every cycle without an accepted read.
- R10: After `dbg_mode` falls, capture continues at the write position where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cof_valid | input | 1 | Change-of-flow capture strobe |
| cof_addr | input | 32 | Fetch address of the change-of-flow instruction |
| dbg_mode | input | 1 | High while the core is in debug mode |
| rd_strobe | input | 1 | Read request from the debug host |
| rd_data | output | 32 | Address returned by the last accepted read |

## Verification
Assertions check the following on every cycle:
- the write position is frozen and the storage is untouched in debug mode;
- the read position steps by exactly one per accepted read and holds otherwise;
- the read position is loaded from the write position on the entry cycle, and an entry and an accepted read never coincide;
- `rd_data` holds between accepted reads and ignores strobes outside debug.

Only the bench's scenarios can show the rest:
- that the addresses come out in true capture order across wrap-around and in a partly filled ring;
- that two full passes match each other and match the last eight captures;
- that capture resumes correctly after debug mode is left.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
   localparam int unsigned TRACE_DEPTH_DEF = 8;
   localparam int unsigned TRACE_ADDR_W_DEF = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cof_trace_capture.sv
module cof_trace_capture #(
   parameter int unsigned DEPTH = cof_trace_pkg::TRACE_DEPTH_DEF,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cof_valid,
   input  logic             dbg_mode,
   input  logic             rd_strobe,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             dbg_entry,
   output logic             rd_en
);
   logic dbg_q;

   generate
      if (!cof_trace_pkg::is_pow2(DEPTH)) begin : g_bad_depth
         $error("cof_trace_capture: DEPTH must be a power of two >= 2");
      end
   endgenerate

   assign wr_en     = cof_valid && !dbg_mode;
   assign dbg_entry = dbg_mode && !dbg_q;
   assign rd_en     = rd_strobe && dbg_mode && dbg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbg_q  <= 1'b0;
         wr_ptr <= '0;
      end else begin
         dbg_q <= dbg_mode;
         if (wr_en) wr_ptr <= PTR_W'(wr_ptr + 1'b1);
      end
   end

   AST_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode |=> $stable(wr_ptr)); // R7
   AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cof_valid && !dbg_mode) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1))); // R1
   AST_ENTRY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_entry && rd_en)); // R8
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
   parameter int unsigned DEPTH  = cof_trace_pkg::TRACE_DEPTH_DEF,
   parameter int unsigned ADDR_W = cof_trace_pkg::TRACE_ADDR_W_DEF,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [ADDR_W-1:0] rd_data
);
   logic [DEPTH-1:0][ADDR_W-1:0] slots;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [ADDR_W-1:0] word_q;
         logic              hit;
         assign hit = wr_en && (wr_ptr == PTR_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '0;
            else if (hit) word_q <= wr_addr;
         end
         assign slots[i] = word_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= slots[rd_ptr];
   end

   AST_SLOTS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(slots)); // R6
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: rtl/cof_trace_rdptr.sv
module cof_trace_rdptr #(
   parameter int unsigned DEPTH = cof_trace_pkg::TRACE_DEPTH_DEF,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_ptr,
   input  logic             step,
   output logic [PTR_W-1:0] rd_ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)    rd_ptr <= '0;
      else if (load) rd_ptr <= load_ptr;
      else if (step) rd_ptr <= PTR_W'(rd_ptr + 1'b1);
   end

   AST_LOAD_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rd_ptr == $past(load_ptr))); // R3
   AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1))); // R4
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(rd_ptr)); // R8
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf #(
   parameter int unsigned DEPTH  = cof_trace_pkg::TRACE_DEPTH_DEF,
   parameter int unsigned ADDR_W = cof_trace_pkg::TRACE_ADDR_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cof_valid,
   input  logic [ADDR_W-1:0] cof_addr,
   input  logic              dbg_mode,
   input  logic              rd_strobe,
   output logic [ADDR_W-1:0] rd_data
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic             wr_en;
   logic [PTR_W-1:0] wr_ptr;
   logic             dbg_entry;
   logic             rd_en;
   logic [PTR_W-1:0] rd_ptr;

   cof_trace_capture #(.DEPTH(DEPTH)) capture_i (
      .clk(clk), .rst_n(rst_n), .cof_valid(cof_valid), .dbg_mode(dbg_mode),
      .rd_strobe(rd_strobe), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .dbg_entry(dbg_entry), .rd_en(rd_en)
   );

   cof_trace_rdptr #(.DEPTH(DEPTH)) rdptr_i (
      .clk(clk), .rst_n(rst_n), .load(dbg_entry), .load_ptr(wr_ptr),
      .step(rd_en), .rd_ptr(rd_ptr)
   );

   cof_trace_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .wr_addr(cof_addr), .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_data(rd_data)
   );

   AST_IGNORED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !dbg_mode) |=> $stable(rd_data)); // R8
endmodule

// File: tb/cof_trace_buf_tb.sv
`timescale 1ns/1ps
module cof_trace_buf_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cof_valid = 1'b0;
   logic [31:0] cof_addr = '0;
   logic        dbg_mode = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // model built from R1: ring of 8, write position wraps
   logic [31:0] m_mem [8];
   int          m_wp = 0;
   logic [31:0] pass_a [8];

   localparam logic [31:0] CAP_TAB [11] = '{
      32'h0000_1000, 32'h0000_1044, 32'h0000_2F10, 32'h8000_0004,
      32'h0001_0200, 32'hFFFF_FFFC, 32'h0000_0000, 32'h1234_5678,
      32'h0000_3A00, 32'hA5A5_5A5C, 32'h0000_0B08 };

   cof_trace_buf dut_i (
      .clk(clk), .rst_n(rst_n), .cof_valid(cof_valid), .cof_addr(cof_addr),
      .dbg_mode(dbg_mode), .rd_strobe(rd_strobe), .rd_data(rd_data)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic capture(input logic [31:0] a, input bit in_dbg);
      cof_valid = 1'b1;
      cof_addr  = a;
      @(negedge clk);
      cof_valid = 1'b0;
      if (!in_dbg) begin
         m_mem[m_wp] = a;
         m_wp = (m_wp + 1) % 8;
      end
   endtask

   task automatic enter_dbg();
      dbg_mode = 1'b1;
      @(negedge clk);
   endtask

   task automatic leave_dbg();
      dbg_mode = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_read(output logic [31:0] v);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      v = rd_data;
   endtask

   // one pass of eight reads against the model, oldest first (R4, R5)
   task automatic read_pass(input string req, input bit keep);
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         do_read(v);
         check(req, v, m_mem[(m_wp + i) % 8]);
         if (keep) pass_a[i] = v;
      end
   endtask

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 8; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      check("R2 rd_data after reset", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R5: empty ring reads as zeros
      enter_dbg();
      read_pass("R2 empty ring pass", 0);
      leave_dbg();

      // R5: partly filled ring, zeros come first
      for (int i = 0; i < 3; i++) capture(CAP_TAB[i] ^ 32'h0F00_0000, 0);
      enter_dbg();
      read_pass("R5 partial ring pass", 0);
      leave_dbg();

      // R1: table walk with idle gaps, wrapping the ring
      for (int i = 0; i < 11; i++) begin
         capture(CAP_TAB[i], 0);
         if (i % 3 == 1) @(negedge clk);
      end
      enter_dbg();
      read_pass("R1 R5 pass one", 1);
      for (int i = 0; i < 8; i++) begin
         do_read(v);
         check("R4 R6 second pass equals first", v, pass_a[i]);
      end
      // R9: rd_data held across idle cycles
      repeat (3) @(negedge clk);
      check("R9 hold while idle", rd_data, pass_a[7]);
      leave_dbg();

      // R8: read strobe outside debug ignored
      do_read(v);
      check("R8 read outside debug", v, pass_a[7]);

      // R8: read in entry cycle ignored, pointer still at oldest
      dbg_mode  = 1'b1;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check("R8 read in entry cycle", rd_data, pass_a[7]);
      read_pass("R3 oldest first after entry", 0);

      // R7: captures in debug ignored
      capture(32'hDEAD_BEE0, 1);
      capture(32'hDEAD_BEE4, 1);
      read_pass("R7 capture in debug ignored", 0);
      leave_dbg();

      // R10: capture resumes where it stopped
      capture(32'h0000_7770, 0);
      capture(32'h0000_7774, 0);
      enter_dbg();
      read_pass("R10 resume after debug", 0);
      leave_dbg();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule